// File: doc/BRIEF.md
# Packed Saturating SIMD Subtractor

This datapath block treats two 128-bit operands as a row of equal-width lanes and subtracts each lane of the second operand from the matching lane of the first. The result is the new value of the first operand, so it goes to the destination output. A 3-bit mode input picks the lane width, either sixteen 8-bit lanes or eight 16-bit lanes. It also picks how results that fall out of range are handled: modular wraparound, clamping to the signed range, or clamping to the unsigned range. The block drives no condition or status flags.

An execution pipeline places the block behind operand read. The default build has an output register. That register takes the lane results on a clock edge where `in_valid` is high and raises `out_valid` on the following cycle. When the parameter `OUT_REG` is cleared, the block is purely combinational and `out_valid` simply follows `in_valid`.

Top module: `simd_sat_sub`

## Requirements
- R1: With mode 3'b001, each 16-bit lane i (bits 16i+15:16i) of `dst` is (a_i − b_i) mod 2^16. The carry is discarded, and the result is correct for both signed and unsigned operands.
- R2: With mode 3'b000, each 8-bit lane i (bits 8i+7:8i) of `dst` is (a_i − b_i) mod 2^8.
- R3: With mode 3'b011, each 16-bit lane holds the signed difference. The lane clamps to 16'h7FFF when the difference exceeds 32767 and to 16'h8000 when it is below −32768. Examples: 16'h8000 − 1 gives 16'h8000, and 16'h7FFF − 16'hFFFF gives 16'h7FFF.
- R4: With mode 3'b010, each 8-bit lane holds the signed difference, clamped to 8'h7F above and to 8'h80 below.
- R5: With mode 3'b101, each 16-bit lane holds the unsigned difference, and any negative difference becomes 16'h0000. Example: 0 − 1 gives 16'h0000.
- R6: With mode 3'b100, each 8-bit lane holds the unsigned difference, and any negative difference becomes 8'h00.
- R7: Mode codes 3'b110 and 3'b111 give an all-zero `dst`.
- R8: In the registered build, `out_valid` equals `in_valid` from the previous cycle. `dst` takes the result of the operands and mode present at an edge where `in_valid` is high, and it holds its value across edges where `in_valid` is low.
- R9: A clock edge with `rst_n` low clears `out_valid` and `dst` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | Lane width and overflow treatment |
| src_a | input | 128 | First operand (minuend) |
| src_b | input | 128 | Second operand (subtrahend) |
| dst | output | 128 | Lane-wise difference |
| out_valid | output | 1 | `dst` holds a new result |

## Verification
The assertions assume that `in_valid` stays low while `rst_n` is low. Without that, a request made in the last reset cycle would look like a lost result once reset is released. The bench holds `in_valid` at zero throughout every reset phase. The per-lane sign and ordering assertions rely on `mode`, `src_a` and `src_b` being stable for the whole cycle in which `in_valid` is high. The bench changes these inputs only on the falling clock edge. Random vectors cover all eight mode codes, and idle cycles with random operands on the inputs check that unaccepted data never reaches `dst`.

// File: rtl/psub_pkg.sv
// Package psub_pkg: shared mode codes for the packed subtractor.
// Assumes bit 0 of a legal code selects 16-bit lanes.
package psub_pkg;
    typedef enum logic [2:0] {
        SUB_WRAP8  = 3'b000,
        SUB_WRAP16 = 3'b001,
        SUB_SSAT8  = 3'b010,
        SUB_SSAT16 = 3'b011,
        SUB_USAT8  = 3'b100,
        SUB_USAT16 = 3'b101
    } sub_mode_e;
endpackage

// File: rtl/sub_lane.sv
// Module sub_lane: one W-bit lane, a - b, with optional signed or unsigned clamp.
// Assumes at most one of sat_s / sat_u is high.
module sub_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sat_s,
    input  logic         sat_u,
    output logic [W-1:0] y
);
    logic [W:0]   diff;
    logic [W-1:0] raw;
    logic         borrow;
    logic         s_ovf;

    // Extended difference: top bit is the unsigned borrow.
    assign diff   = {1'b0, a} - {1'b0, b};
    assign raw    = diff[W-1:0];
    assign borrow = diff[W];
    // Signed overflow: operands differ in sign and result sign departs from a.
    assign s_ovf  = (a[W-1] ^ b[W-1]) & (raw[W-1] ^ a[W-1]);

    // Pick wrapped value or clamp bound.
    always_comb begin
        y = raw;
        if (sat_u && borrow)
            y = '0;
        else if (sat_s && s_ovf)
            y = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/lane_bank.sv
// Module lane_bank: splits DATA_W into LANE_W lanes and subtracts each.
// Assumes DATA_W is a multiple of LANE_W.
module lane_bank #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sat_s,
    input  logic              sat_u,
    output logic [DATA_W-1:0] y
);
    localparam int NLANE = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        sub_lane #(.W(LANE_W)) u_lane (
            .a     (a[i*LANE_W +: LANE_W]),
            .b     (b[i*LANE_W +: LANE_W]),
            .sat_s (sat_s),
            .sat_u (sat_u),
            .y     (y[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_sat_sub.sv
// Module simd_sat_sub: packed subtract in 8- or 16-bit lanes, with wrap,
// signed clamp or unsigned clamp, and an optional output register.
// Assumes DATA_W is a multiple of 16 and inputs are stable through a cycle.
module simd_sat_sub
    import psub_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] dst,
    output logic              out_valid
);
    localparam int N16 = DATA_W / 16;
    localparam int N8  = DATA_W / 8;

    logic              sat_s, sat_u, wide, legal;
    logic [DATA_W-1:0] res8, res16, res;

    // Decode mode into lane width and clamp kind.
    always_comb begin
        legal = (mode <= 3'(SUB_USAT16));
        wide  = mode[0];
        sat_s = (mode == 3'(SUB_SSAT8))  || (mode == 3'(SUB_SSAT16));
        sat_u = (mode == 3'(SUB_USAT8))  || (mode == 3'(SUB_USAT16));
    end

    lane_bank #(.DATA_W(DATA_W), .LANE_W(8)) u_bank8 (
        .a(src_a), .b(src_b), .sat_s(sat_s), .sat_u(sat_u), .y(res8)
    );
    lane_bank #(.DATA_W(DATA_W), .LANE_W(16)) u_bank16 (
        .a(src_a), .b(src_b), .sat_s(sat_s), .sat_u(sat_u), .y(res16)
    );

    // Select the width in use; reserved codes give zero.
    always_comb begin
        res = '0;
        if (legal) res = wide ? res16 : res8;
    end

    if (OUT_REG) begin : g_reg
        // Capture result on accepted input; valid follows input a cycle later.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                dst       <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) dst <= res;
            end
        end

        AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);                                        // R8
        AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);                                      // R8
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(dst));                                    // R8
        AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(mode) >= 3'b110) |-> (dst == '0));          // R7

        for (genvar i = 0; i < N16; i++) begin : g_chk16
            AST_US16_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(mode) == 3'(SUB_USAT16))
                |-> (dst[i*16 +: 16] <= $past(src_a[i*16 +: 16])));         // R5
            AST_SS16_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(mode) == 3'(SUB_SSAT16)
                 && ($past(src_a[i*16+15]) != $past(src_b[i*16+15])))
                |-> (dst[i*16+15] == $past(src_a[i*16+15])));              // R3
        end
        for (genvar j = 0; j < N8; j++) begin : g_chk8
            AST_US8_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(mode) == 3'(SUB_USAT8))
                |-> (dst[j*8 +: 8] <= $past(src_a[j*8 +: 8])));             // R6
            AST_SS8_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(mode) == 3'(SUB_SSAT8)
                 && ($past(src_a[j*8+7]) != $past(src_b[j*8+7])))
                |-> (dst[j*8+7] == $past(src_a[j*8+7])));                  // R4
        end
    end else begin : g_comb
        // Pass-through variant: no storage.
        assign dst       = res;
        assign out_valid = in_valid;
    end
endmodule

// File: tb/simd_sat_sub_test.sv
module simd_sat_sub_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic [127:0] src_a = '0, src_b = '0;
    logic [127:0] dst;
    logic         out_valid;

    int checks = 0, errors = 0;
    logic [127:0] exp_dst = '0;
    logic         exp_valid = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    simd_sat_sub uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .src_a(src_a), .src_b(src_b), .dst(dst), .out_valid(out_valid)
    );

    // Behavioural lane model with integer arithmetic.
    function automatic logic [127:0] model(logic [2:0] m, logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        int w;
        longint full, half, av, bv, d;
        if (m > 3'b101) return '0;
        w    = m[0] ? 16 : 8;
        full = longint'(1) << w;
        half = full / 2;
        for (int i = 0; i < 128 / w; i++) begin
            av = longint'((a >> (i*w)) & 128'(full - 1));
            bv = longint'((b >> (i*w)) & 128'(full - 1));
            if (m[2:1] == 2'b01) begin
                if (av >= half) av -= full;
                if (bv >= half) bv -= full;
            end
            d = av - bv;
            if (m[2:1] == 2'b01) begin
                if (d > half - 1) d = half - 1;
                if (d < -half)    d = -half;
            end
            if (m[2:1] == 2'b10 && d < 0) d = 0;
            r |= 128'(d & (full - 1)) << (i*w);
        end
        return r;
    endfunction

    function automatic string tag(logic [2:0] m);
        case (m)
            3'b000:  return "R2";
            3'b001:  return "R1";
            3'b010:  return "R4";
            3'b011:  return "R3";
            3'b100:  return "R6";
            3'b101:  return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(string t);
        checks++;
        if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, exp_valid);
        end
        checks++;
        if (dst !== exp_dst) begin
            errors++;
            $display("FAIL %s dst actual %h expected %h", t, dst, exp_dst);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cycle(logic v, logic [2:0] m, logic [127:0] a, logic [127:0] b, string t);
        in_valid = v; mode = m; src_a = a; src_b = b;
        @(posedge clk);
        exp_valid = v;
        if (v) exp_dst = model(m, a, b);
        @(negedge clk);
        compare(t);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        exp_valid = 1'b0; exp_dst = '0;
        @(negedge clk);
        compare("R9");
        rst_n = 1'b1;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();                                                  // R9
        // Boundary cases.
        cycle(1, 3'b101, '0, {8{16'h0001}}, "R5");                   // R5: 0-1 -> 0000
        cycle(1, 3'b100, '0, {16{8'h01}}, "R6");                     // R6: 0-1 -> 00
        cycle(1, 3'b011, {8{16'h8000}}, {8{16'h0001}}, "R3");        // R3: -> 8000
        cycle(1, 3'b011, {8{16'h7FFF}}, {8{16'hFFFF}}, "R3");        // R3: -> 7FFF
        cycle(1, 3'b010, {8{16'h807F}}, {8{16'h01FF}}, "R4");        // R4: clamp both ends
        cycle(1, 3'b001, {8{16'h8000}}, {8{16'h0001}}, "R1");        // R1: -> 7FFF wrap
        cycle(1, 3'b000, {16{8'h00}}, {16{8'h01}}, "R2");            // R2: -> FF
        cycle(1, 3'b110, {128{1'b1}}, '0, "R7");                     // R7
        // Idle cycles with changing inputs must not disturb dst.
        cycle(1, 3'b001, rnd128(), rnd128(), "R1");
        for (int k = 0; k < 4; k++) cycle(0, 3'(k), rnd128(), rnd128(), "R8");
        // Random vectors across every code.
        for (int k = 0; k < 400; k++) begin
            logic [2:0] m = 3'($urandom_range(0, 7));
            logic       v = ($urandom_range(0, 3) != 0);
            cycle(v, m, rnd128(), rnd128(), v ? tag(m) : "R8");
        end
        // Reset mid-run clears a held result.
        cycle(1, 3'b001, {128{1'b1}}, '0, "R1");
        do_reset();                                                  // R9
        cycle(0, 3'b000, '0, '0, "R9");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule